// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Data Path

This block carries bytes between a processor register port and a pair of asynchronous serial lines. Each direction has a hidden shift register behind a holding register that the processor can see. On the receive side, the shift register collects one frame from the incoming line. When the frame is complete, the byte moves into a read-only holding register and a ready flag is raised, so the next frame can be received at once. On the transmit side, the processor writes a holding register. As soon as the shifter is free, that byte moves into the shifter and is sent.

Frames have one low start bit, eight data bits sent least significant bit first, and one high stop bit. The line idles high. Bit timing comes from a baud tick input that pulses once per oversample period. A bit lasts OSR ticks, which is 16 by default. While a frame is being sent, the processor can write the next byte. That byte then follows the current stop bit with no idle gap. A completed frame that arrives while the receive holding register is still unread is discarded and raises a sticky overrun flag.

Top module: `dbs_uart_path`

## Requirements
- R1: After reset: rdr_data = 0x00, tdr_data = 0xFF, tx_empty = 1, rx_full = 0, txd = 1, tx_end = 1, overrun = 0, frame_err = 0.
- R2: A transmitted frame is a 0 start bit, then data bits 0 to 7 in that order, then a 1 stop bit. Each bit lasts OSR baud ticks, and the line is 1 while nothing is being sent.
- R3: A pulse on tdr_wr stores tdr_wdata into tdr_data and clears tx_empty on the next clock. tdr_data can be read back at any time.
- R4: When the shifter is idle and a written byte is waiting, the byte is loaded on the following clock. txd then drops to the start bit and tx_empty returns to 1.
- R5: If a byte is waiting when a stop bit ends, the next start bit begins on that same baud tick. The stop bit therefore lasts exactly OSR ticks, with no idle gap.
- R6: tx_end is 1 exactly when the shifter is idle and tx_empty is 1.
- R7: The receiver samples the synchronised line on each baud tick. It confirms a start bit at its mid-point (OSR/2 ticks) and samples each data bit and the stop bit OSR ticks apart. A finished frame is placed in rdr_data and sets rx_full.
- R8: A low pulse on rxd that is shorter than half a bit time is not taken as a start bit. rx_full and rdr_data are left unchanged.
- R9: A pulse on rdr_rd clears rx_full.
- R10: If a frame completes while rx_full is 1 and no read pulse arrives in the same cycle, rdr_data keeps its old byte and overrun is set. overrun stays set until a pulse on ovr_clr.
- R11: When a frame is transferred, frame_err is set to 1 if its stop bit sampled 0 and to 0 otherwise. The data is transferred in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse per oversample period |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| tdr_wr | input | 1 | Write strobe for the transmit holding register |
| tdr_wdata | input | DATA_W | Byte to transmit |
| tdr_data | output | DATA_W | Transmit holding register contents |
| rdr_rd | input | 1 | Read strobe, clears rx_full |
| rdr_data | output | DATA_W | Receive holding register contents |
| ovr_clr | input | 1 | Clears the overrun flag |
| rx_full | output | 1 | Receive holding register holds unread data |
| tx_empty | output | 1 | Transmit holding register can take a byte |
| tx_end | output | 1 | Transmitter fully idle |
| overrun | output | 1 | Sticky overrun flag |
| frame_err | output | 1 | Stop bit of the last transferred frame was 0 |

## Verification
The bench builds the block with DATA_W = 8 and OSR = 16, and pulses the baud tick every second clock. At that setting a full frame takes 320 clocks. This short frame lets the bench loop the transmit line back into the receiver and send all 256 byte values through both shifters. On its own serial line, the bench drives frames with a bad stop bit, frames that arrive while the holding register is still unread, and a short start glitch. It also measures the stop-to-start spacing of two chained transmit frames against the bit time.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/dbs_sync.sv
module dbs_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= RST_VAL;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dbs_rx.sv
module dbs_rx
  import dbs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              line_s,
  input  logic              rd_stb,
  input  logic              ovr_clr,
  output logic [DATA_W-1:0] rdr_q,
  output logic              full_q,
  output logic              ovr_q,
  output logic              ferr_q
);
  localparam int CW = (OSR > 2) ? $clog2(OSR) : 1;
  localparam int BW = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [BW-1:0] LASTBIT = BW'(DATA_W - 1);

  rx_state_t         st;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bitn;
  logic [DATA_W-1:0] sh;
  logic              done;
  logic              full_eff;

  assign done     = tick && (st == RX_STOP) && (cnt == LAST);
  assign full_eff = full_q && !rd_stb;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= RX_IDLE;
      cnt  <= '0;
      bitn <= '0;
      sh   <= '0;
    end else if (tick) begin
      case (st)
        RX_IDLE: if (!line_s) begin
          st  <= RX_START;
          cnt <= '0;
        end
        RX_START: if (cnt == MID) begin
          cnt  <= '0;
          bitn <= '0;
          st   <= line_s ? RX_IDLE : RX_DATA;
        end else cnt <= cnt + 1'b1;
        RX_DATA: if (cnt == LAST) begin
          cnt <= '0;
          sh  <= {line_s, sh[DATA_W-1:1]};
          if (bitn == LASTBIT) st <= RX_STOP;
          else bitn <= bitn + 1'b1;
        end else cnt <= cnt + 1'b1;
        RX_STOP: if (cnt == LAST) begin
          cnt <= '0;
          st  <= RX_IDLE;
        end else cnt <= cnt + 1'b1;
        default: st <= RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdr_q  <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      if (ovr_clr) ovr_q <= 1'b0;
      if (done) begin
        if (full_eff) begin
          ovr_q <= 1'b1;
        end else begin
          rdr_q  <= sh;
          full_q <= 1'b1;
          ferr_q <= !line_s;
        end
      end else if (rd_stb) begin
        full_q <= 1'b0;
      end
    end
  end

  // R10
  overrun_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (done && full_q && !rd_stb) |=> (ovr_q && $stable(rdr_q)));
  // R7
  rx_load_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !full_q) |=> full_q);
  // R9
  rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !done) |=> !full_q);
  // R11
  ferr_track_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !full_eff) |=> (ferr_q == !$past(line_s)));
endmodule

// File: rtl/dbs_tx.sv
module dbs_tx #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] tdr_q,
  output logic              tdre_q,
  output logic              txd_q,
  output logic              busy_q
);
  localparam int CW = (OSR > 2) ? $clog2(OSR) : 1;
  localparam int BW = $clog2(DATA_W + 2);
  localparam logic [CW-1:0] LAST    = CW'(OSR - 1);
  localparam logic [BW-1:0] LASTBIT = BW'(DATA_W + 1);

  logic [CW-1:0]   cnt;
  logic [BW-1:0]   bitn;
  logic [DATA_W:0] frm;
  logic            bit_end;
  logic            eof;
  logic            load;

  assign bit_end = busy_q && tick && (cnt == LAST);
  assign eof     = bit_end && (bitn == LASTBIT);
  assign load    = (!busy_q || eof) && !tdre_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tdr_q  <= '1;
      tdre_q <= 1'b1;
    end else begin
      if (wr_stb) tdr_q <= wdata;
      if (wr_stb) tdre_q <= 1'b0;
      else if (load) tdre_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frm    <= '1;
      cnt    <= '0;
      bitn   <= '0;
      busy_q <= 1'b0;
      txd_q  <= 1'b1;
    end else if (load) begin
      frm    <= {1'b1, tdr_q};
      cnt    <= '0;
      bitn   <= '0;
      busy_q <= 1'b1;
      txd_q  <= 1'b0;
    end else if (busy_q && tick) begin
      if (cnt == LAST) begin
        cnt <= '0;
        if (bitn == LASTBIT) begin
          busy_q <= 1'b0;
          txd_q  <= 1'b1;
        end else begin
          txd_q <= frm[0];
          frm   <= {1'b1, frm[DATA_W:1]};
          bitn  <= bitn + 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R3
  wr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !tdre_q);
  // R4
  idle_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !tdre_q && !wr_stb) |=> (busy_q && tdre_q && !txd_q));
  // R5
  chain_chk: assert property (@(posedge clk) disable iff (rst)
    (eof && !tdre_q) |=> (busy_q && !txd_q));
  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> txd_q);
endmodule

// File: rtl/dbs_uart_path.sv
module dbs_uart_path #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              rxd,
  output logic              txd,
  input  logic              tdr_wr,
  input  logic [DATA_W-1:0] tdr_wdata,
  output logic [DATA_W-1:0] tdr_data,
  input  logic              rdr_rd,
  output logic [DATA_W-1:0] rdr_data,
  input  logic              ovr_clr,
  output logic              rx_full,
  output logic              tx_empty,
  output logic              tx_end,
  output logic              overrun,
  output logic              frame_err
);
  logic rxd_s;
  logic tx_busy;

  dbs_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (rxd),
    .q   (rxd_s)
  );

  dbs_rx #(.DATA_W(DATA_W), .OSR(OSR)) u_rx (
    .clk     (clk),
    .rst     (rst),
    .tick    (baud_tick),
    .line_s  (rxd_s),
    .rd_stb  (rdr_rd),
    .ovr_clr (ovr_clr),
    .rdr_q   (rdr_data),
    .full_q  (rx_full),
    .ovr_q   (overrun),
    .ferr_q  (frame_err)
  );

  dbs_tx #(.DATA_W(DATA_W), .OSR(OSR)) u_tx (
    .clk    (clk),
    .rst    (rst),
    .tick   (baud_tick),
    .wr_stb (tdr_wr),
    .wdata  (tdr_wdata),
    .tdr_q  (tdr_data),
    .tdre_q (tx_empty),
    .txd_q  (txd),
    .busy_q (tx_busy)
  );

  assign tx_end = !tx_busy && tx_empty;

  // R6
  tx_end_line_chk: assert property (@(posedge clk) disable iff (rst)
    tx_end |-> txd);
endmodule

// File: tb/dbs_uart_path_test.sv
module dbs_uart_path_test;
  localparam int DW  = 8;
  localparam int OSR = 16;
  localparam int BITC = 2 * OSR;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic baud_tick = 1'b0;
  logic rxd, txd;
  logic tdr_wr = 1'b0;
  logic [DW-1:0] tdr_wdata = '0;
  logic [DW-1:0] tdr_data, rdr_data;
  logic rdr_rd = 1'b0;
  logic ovr_clr = 1'b0;
  logic rx_full, tx_empty, tx_end, overrun, frame_err;
  logic loop_en = 1'b0;
  logic rxd_b = 1'b1;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  assign rxd = loop_en ? txd : rxd_b;

  always #5 clk = ~clk;

  dbs_uart_path #(.DATA_W(DW), .OSR(OSR)) uut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .rxd(rxd), .txd(txd),
    .tdr_wr(tdr_wr), .tdr_wdata(tdr_wdata), .tdr_data(tdr_data),
    .rdr_rd(rdr_rd), .rdr_data(rdr_data), .ovr_clr(ovr_clr),
    .rx_full(rx_full), .tx_empty(tx_empty), .tx_end(tx_end),
    .overrun(overrun), .frame_err(frame_err)
  );

  initial begin
    forever begin
      @(negedge clk);
      baud_tick = ~baud_tick;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic cpu_write(input logic [DW-1:0] b);
    @(negedge clk); tdr_wr = 1'b1; tdr_wdata = b;
    @(negedge clk); tdr_wr = 1'b0;
  endtask

  task automatic cpu_read();
    @(negedge clk); rdr_rd = 1'b1;
    @(negedge clk); rdr_rd = 1'b0;
  endtask

  task automatic wait_full();
    for (int i = 0; i < 2000; i++) begin
      if (rx_full) break;
      @(negedge clk);
    end
  endtask

  task automatic rx_send(input logic [DW-1:0] b, input logic stopv);
    @(negedge clk); rxd_b = 1'b0;
    repeat (BITC) @(negedge clk);
    for (int k = 0; k < DW; k++) begin
      rxd_b = b[k];
      repeat (BITC) @(negedge clk);
    end
    rxd_b = stopv;
    repeat (BITC) @(negedge clk);
    rxd_b = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      report();
    end
  end

  initial begin
    logic [DW-1:0] pat;
    int gap;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(rdr_data == 8'h00, "R1 rdr", rdr_data, 8'h00);
    chk(tdr_data == 8'hFF, "R1 tdr", tdr_data, 8'hFF);
    chk(tx_empty && !rx_full && txd && tx_end && !overrun && !frame_err,
        "R1 flags", {tx_empty, rx_full, txd, tx_end, overrun, frame_err}, 6'b101100);

    // R3 / R4 / R6 / R2: one frame watched on txd
    pat = 8'hA5;
    @(negedge clk); tdr_wr = 1'b1; tdr_wdata = pat;
    @(negedge clk); tdr_wr = 1'b0;
    chk(!tx_empty, "R3 tx_empty cleared", tx_empty, 0);
    chk(tdr_data == pat, "R3 tdr readback", tdr_data, pat);
    chk(!tx_end, "R6 tx_end while pending", tx_end, 0);
    @(negedge clk);
    chk(tx_empty && !txd, "R4 loaded", {tx_empty, txd}, 2'b10);
    repeat (BITC/2) @(negedge clk);
    chk(!txd, "R2 start bit", txd, 0);
    chk(!tx_end, "R6 tx_end while busy", tx_end, 0);
    for (int k = 0; k < DW; k++) begin
      repeat (BITC) @(negedge clk);
      chk(txd == pat[k], "R2 data bit", txd, pat[k]);
    end
    repeat (BITC) @(negedge clk);
    chk(txd, "R2 stop bit", txd, 1);
    repeat (BITC) @(negedge clk);
    chk(tx_end && txd, "R6 tx_end idle", {tx_end, txd}, 2'b11);

    // R5 back-to-back: stop bit lasts exactly one bit time
    cpu_write(8'h3C);
    cpu_write(8'h81);
    while (txd !== 1'b0) @(negedge clk);
    repeat (BITC/2) @(negedge clk);
    repeat (7 * BITC) @(negedge clk);
    while (txd !== 1'b1) @(negedge clk);
    gap = 0;
    while (txd === 1'b1 && gap < 4 * BITC) begin
      @(negedge clk);
      gap++;
    end
    chk(gap == BITC, "R5 stop-to-start gap", gap, BITC);
    repeat (11 * BITC) @(negedge clk);

    // R7 / R3 loopback sweep of every byte value
    loop_en = 1'b1;
    cpu_read();
    repeat (4) @(negedge clk);
    for (int v = 0; v < 256; v++) begin
      cpu_write(8'(v));
      chk(tdr_data == 8'(v), "R3 tdr sweep", tdr_data, v);
      wait_full();
      chk(rx_full && rdr_data == 8'(v), "R7 loopback byte", rdr_data, v);
      cpu_read();
      chk(!rx_full, "R9 read clears", rx_full, 0);
    end
    repeat (2 * BITC) @(negedge clk);
    loop_en = 1'b0;
    repeat (4 * BITC) @(negedge clk);

    // R10 overrun
    rx_send(8'h11, 1'b1);
    chk(rx_full && rdr_data == 8'h11, "R7 direct rx", rdr_data, 8'h11);
    rx_send(8'h22, 1'b1);
    chk(overrun, "R10 overrun set", overrun, 1);
    chk(rdr_data == 8'h11, "R10 old byte kept", rdr_data, 8'h11);
    cpu_read();
    chk(overrun, "R10 overrun sticky", overrun, 1);
    @(negedge clk); ovr_clr = 1'b1;
    @(negedge clk); ovr_clr = 1'b0;
    chk(!overrun, "R10 overrun cleared", overrun, 0);

    // R11 framing error
    rx_send(8'h5A, 1'b0);
    chk(frame_err, "R11 frame_err set", frame_err, 1);
    chk(rx_full && rdr_data == 8'h5A, "R11 data transferred", rdr_data, 8'h5A);
    cpu_read();
    repeat (3 * BITC) @(negedge clk);
    rx_send(8'h33, 1'b1);
    chk(!frame_err && rdr_data == 8'h33, "R11 frame_err cleared", frame_err, 0);
    cpu_read();

    // R8 short start glitch
    @(negedge clk); rxd_b = 1'b0;
    repeat (BITC/4) @(negedge clk);
    rxd_b = 1'b1;
    repeat (12 * BITC) @(negedge clk);
    chk(!rx_full, "R8 glitch ignored", rx_full, 0);
    chk(rdr_data == 8'h33, "R8 rdr unchanged", rdr_data, 8'h33);

    finished = 1'b1;
    report();
  end
endmodule